// File: doc/BRIEF.md
# Two-Channel DMA Controller

This block moves data without processor help. Each of its two channels copies a programmed number of items from a source address to a destination address. The endpoints can be memory or I/O, in any combination. Every item is read from the source and then written to the destination. After each item, both addresses step forward by the item size. A simple register port programs the channels. A request/grant pair and a single-beat read/write port make up the master side of the system bus.

A channel starts when software sets its request bit, or while the channel's own external request line is high, if the channel is set to external mode. Two arbitration schemes are available: fixed, where channel 0 always wins, and rotating, where the channel just served drops to the lowest priority. Two bus-ownership modes are available per channel. Cycle-steal gives the bus back after every item. Burst keeps it until the whole programmed block is done. A channel stops and reports an error if the chosen size is reserved or if either address is misaligned for that size. Each channel has its own maskable interrupt line.

Register port: `reg_addr[3]` selects the channel and `reg_addr[2:0]` selects the field. The fields are:
- 0: source address
- 1: destination address
- 2: count
- 3: control, with bit 0 enable, bits 2:1 size, bit 3 burst, bit 4 external request, bit 5 interrupt enable
- 4: status, with bit 0 done and bit 1 error; write 1 to clear a bit
- 5: software request, write bit 0 = 1 to set
- 7: shared mode register, bit 0 = 1 selects rotating priority

Top module: `dma2_ctrl`

## Requirements
- R1: After reset, `bus_req`, `m_valid` and both `irq` bits are 0, and the status and software-request fields of both channels read 0.
- R2: A count value N from 1 to 2^CNT_W-1 gives exactly N transfers. A count of 0 gives 2^CNT_W transfers.
- R3: Size code 0 is a byte, 1 is a half-word and 2 is a word. After each transfer, both addresses advance by 1, 2 or 4. `m_size` carries the code.
- R4: Each transfer issues one read at the source address and then one write to the destination address. The write carries the data returned by that read. The address is held while `m_ack` is low.
- R5: With the mode bit at 0, when both channels request at once, channel 0 is served first.
- R6: With the mode bit at 1, when both channels request, the channel served most recently loses.
- R7: In cycle-steal mode, `bus_req` rises once for each transfer and falls only after that transfer's write is acknowledged.
- R8: In burst mode, `bus_req` rises once and stays high until the last transfer of the block completes.
- R9: Setting the software request bit starts the channel. The bit reads 0 again once the block completes.
- R10: A channel in external mode does nothing while its `ext_req` input is low. It transfers while the input is high.
- R11: Size code 3, or a source or destination address not aligned to the size, sets status bit 1. In that case no bus request or access is made and the channel stops.
- R12: `irq[i]` is high exactly when channel i's interrupt enable is set and its done or error bit is set. Writing 1 to a status bit clears it.
- R13: Arbitration happens only between transfers. A channel in burst mode completes its whole block before the other channel is granted, even if the other channel has higher priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select: bit 3 is the channel, bits 2:0 the field |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| ext_req | input | 2 | External request, one per channel |
| irq | output | 2 | Interrupt, one per channel |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| m_valid | output | 1 | Bus access valid |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | AW | Access address |
| m_size | output | 2 | Access size code |
| m_wdata | output | DW | Write data |
| m_rdata | input | DW | Read data |
| m_ack | input | 1 | Access acknowledge |

## Verification
Copies are run at each of the three sizes, with both ownership modes and with an acknowledge that stalls every other cycle. The logged write addresses and data then separate the address step, the data forwarding and the counting of bus requests. The two channels are made to request together under fixed and rotating priority. Their interleaving tells the two schemes apart. A burst that starts while the higher-priority channel is idle, and is then contested by that channel, shows that a block is never preempted. A count of zero, a misaligned address, a reserved size, a held-low external request and a masked interrupt probe the boundary behaviour.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } xsize_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_REQ,
      ST_RD,
      ST_WR
   } eng_st_e;

   localparam logic [2:0] F_SRC  = 3'd0;
   localparam logic [2:0] F_DST  = 3'd1;
   localparam logic [2:0] F_CNT  = 3'd2;
   localparam logic [2:0] F_CTL  = 3'd3;
   localparam logic [2:0] F_STS  = 3'd4;
   localparam logic [2:0] F_SWR  = 3'd5;
   localparam logic [2:0] F_MODE = 3'd7;

   // true when the size code is reserved or either address breaks alignment
   function automatic logic bad_align(input logic [1:0] sz,
                                      input logic [1:0] a,
                                      input logic [1:0] b);
      case (sz)
         SZ_BYTE: return 1'b0;
         SZ_HALF: return a[0] | b[0];
         SZ_WORD: return |{a, b};
         default: return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
   import dma2_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int CNT_W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_field,
   input  logic [DW-1:0] wr_data,
   input  logic [2:0]    rd_field,
   output logic [DW-1:0] rd_data,
   input  logic          ext_req,
   input  logic          step,
   input  logic          fail,
   output logic [AW-1:0] src,
   output logic [AW-1:0] dst,
   output logic [1:0]    size,
   output logic          burst,
   output logic          pending,
   output logic          last,
   output logic          irq
);

   localparam int            RW   = CNT_W + 1;
   localparam logic [RW-1:0] FULL = RW'(1) << CNT_W;
   localparam logic [RW-1:0] ONE  = RW'(1);

   logic [AW-1:0] src_q, dst_q, inc;
   logic [RW-1:0] rem_q;
   logic [1:0]    size_q;
   logic          en_q, burst_q, ext_q, ien_q, done_q, err_q, sw_q;

   assign inc = AW'(3'd1 << size_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= '0;
         dst_q   <= '0;
         rem_q   <= '0;
         size_q  <= SZ_BYTE;
         en_q    <= 1'b0;
         burst_q <= 1'b0;
         ext_q   <= 1'b0;
         ien_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         sw_q    <= 1'b0;
      end else begin
         if (step) begin
            src_q <= src_q + inc;
            dst_q <= dst_q + inc;
            rem_q <= rem_q - ONE;
            if (rem_q == ONE) begin
               done_q <= 1'b1;
               sw_q   <= 1'b0;
            end
         end
         if (fail) begin
            err_q <= 1'b1;
            sw_q  <= 1'b0;
         end
         if (wr_en) begin
            case (wr_field)
               F_SRC: src_q <= wr_data[AW-1:0];
               F_DST: dst_q <= wr_data[AW-1:0];
               F_CNT: rem_q <= (wr_data[CNT_W-1:0] == '0) ? FULL
                                                          : {1'b0, wr_data[CNT_W-1:0]};
               F_CTL: begin
                  en_q    <= wr_data[0];
                  size_q  <= wr_data[2:1];
                  burst_q <= wr_data[3];
                  ext_q   <= wr_data[4];
                  ien_q   <= wr_data[5];
               end
               F_STS: begin
                  if (wr_data[0]) done_q <= 1'b0;
                  if (wr_data[1]) err_q  <= 1'b0;
               end
               F_SWR: if (wr_data[0]) sw_q <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (rd_field)
         F_SRC:   rd_data = DW'(src_q);
         F_DST:   rd_data = DW'(dst_q);
         F_CNT:   rd_data = DW'(rem_q[CNT_W-1:0]);
         F_CTL:   rd_data = DW'({ien_q, ext_q, burst_q, size_q, en_q});
         F_STS:   rd_data = DW'({err_q, done_q});
         F_SWR:   rd_data = DW'(sw_q);
         default: rd_data = '0;
      endcase
   end

   assign src     = src_q;
   assign dst     = dst_q;
   assign size    = size_q;
   assign burst   = burst_q;
   assign last    = (rem_q == ONE);
   assign pending = en_q & ~done_q & ~err_q & (rem_q != '0) & (sw_q | (ext_q & ext_req));
   assign irq     = ien_q & (done_q | err_q);

endmodule

// File: rtl/dma2_arb.sv
module dma2_arb #(
   parameter bit ROTATE_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pend,
   input  logic       rotate,
   input  logic       served,
   input  logic       served_idx,
   output logic       gnt_valid,
   output logic       gnt_idx
);

   logic prefer1;

   generate
      if (ROTATE_EN) begin : g_rr
         logic last_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      last_q <= 1'b1;
            else if (served) last_q <= served_idx;
         end
         assign prefer1 = rotate & ~last_q;
      end else begin : g_fixed
         assign prefer1 = 1'b0;
      end
   endgenerate

   assign gnt_valid = |pend;
   assign gnt_idx   = pend[1] & (~pend[0] | prefer1);

endmodule

// File: rtl/dma2_xfer.sv
module dma2_xfer
   import dma2_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gnt_valid,
   input  logic          gnt_idx,
   input  logic [AW-1:0] cur_src,
   input  logic [AW-1:0] cur_dst,
   input  logic [1:0]    cur_size,
   input  logic          cur_burst,
   input  logic          cur_last,
   output logic          view_idx,
   output logic          step,
   output logic          fail,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic          m_valid,
   output logic          m_we,
   output logic [AW-1:0] m_addr,
   output logic [1:0]    m_size,
   output logic [DW-1:0] m_wdata,
   input  logic [DW-1:0] m_rdata,
   input  logic          m_ack
);

   eng_st_e       state_q;
   logic          sel_q;
   logic [DW-1:0] data_q;
   logic          bad;

   assign bad      = bad_align(cur_size, cur_src[1:0], cur_dst[1:0]);
   assign view_idx = (state_q == ST_IDLE) ? gnt_idx : sel_q;
   assign fail     = (state_q == ST_IDLE) & gnt_valid & bad;
   assign step     = (state_q == ST_WR) & m_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sel_q   <= 1'b0;
         data_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (gnt_valid && !bad) begin
               sel_q   <= gnt_idx;
               state_q <= ST_REQ;
            end
            ST_REQ: if (bus_gnt) state_q <= ST_RD;
            ST_RD: if (m_ack) begin
               data_q  <= m_rdata;
               state_q <= ST_WR;
            end
            ST_WR: if (m_ack) begin
               state_q <= (cur_burst && !cur_last) ? ST_RD : ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bus_req = (state_q != ST_IDLE);
   assign m_valid = (state_q == ST_RD) | (state_q == ST_WR);
   assign m_we    = (state_q == ST_WR);
   assign m_addr  = (state_q == ST_WR) ? cur_dst : cur_src;
   assign m_size  = cur_size;
   assign m_wdata = data_q;

endmodule

// File: rtl/dma2_ctrl.sv
module dma2_ctrl
   import dma2_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int CNT_W     = 16,
   parameter bit ROTATE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [3:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic [1:0]    ext_req,
   output logic [1:0]    irq,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic          m_valid,
   output logic          m_we,
   output logic [AW-1:0] m_addr,
   output logic [1:0]    m_size,
   output logic [DW-1:0] m_wdata,
   input  logic [DW-1:0] m_rdata,
   input  logic          m_ack
);

   localparam int NCH = 2;

   generate
      if (AW < 3 || AW > DW)         begin : g_bad_aw  $error("AW must lie in 3..DW");   end
      if (CNT_W < 1 || CNT_W >= DW)  begin : g_bad_cnt $error("CNT_W must lie in 1..DW-1"); end
   endgenerate

   logic [AW-1:0] src_a [NCH];
   logic [AW-1:0] dst_a [NCH];
   logic [1:0]    size_a [NCH];
   logic [DW-1:0] rd_a [NCH];
   logic [NCH-1:0] burst_v, last_v, pend_v;
   logic          view_idx, eng_step, eng_fail, gnt_valid, gnt_idx;
   logic          rotate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rotate_q <= 1'b0;
      else if (reg_we && reg_addr[2:0] == F_MODE) rotate_q <= reg_wdata[0];
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         dma2_chan #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_we && reg_addr[3] == c[0] && reg_addr[2:0] != F_MODE),
            .wr_field (reg_addr[2:0]),
            .wr_data  (reg_wdata),
            .rd_field (reg_addr[2:0]),
            .rd_data  (rd_a[c]),
            .ext_req  (ext_req[c]),
            .step     (eng_step && view_idx == c[0]),
            .fail     (eng_fail && view_idx == c[0]),
            .src      (src_a[c]),
            .dst      (dst_a[c]),
            .size     (size_a[c]),
            .burst    (burst_v[c]),
            .pending  (pend_v[c]),
            .last     (last_v[c]),
            .irq      (irq[c])
         );
      end
   endgenerate

   assign reg_rdata = (reg_addr[2:0] == F_MODE) ? DW'(rotate_q) : rd_a[reg_addr[3]];

   dma2_arb #(.ROTATE_EN(ROTATE_EN)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend       (pend_v),
      .rotate     (rotate_q),
      .served     (eng_step),
      .served_idx (view_idx),
      .gnt_valid  (gnt_valid),
      .gnt_idx    (gnt_idx)
   );

   dma2_xfer #(.AW(AW), .DW(DW)) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_idx),
      .cur_src   (src_a[view_idx]),
      .cur_dst   (dst_a[view_idx]),
      .cur_size  (size_a[view_idx]),
      .cur_burst (burst_v[view_idx]),
      .cur_last  (last_v[view_idx]),
      .view_idx  (view_idx),
      .step      (eng_step),
      .fail      (eng_fail),
      .bus_req   (bus_req),
      .bus_gnt   (bus_gnt),
      .m_valid   (m_valid),
      .m_we      (m_we),
      .m_addr    (m_addr),
      .m_size    (m_size),
      .m_wdata   (m_wdata),
      .m_rdata   (m_rdata),
      .m_ack     (m_ack)
   );

endmodule

// File: rtl/dma2_ctrl_chk.sv
module dma2_ctrl_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req,
   input logic          bus_gnt,
   input logic          m_valid,
   input logic          m_we,
   input logic [AW-1:0] m_addr,
   input logic [1:0]    m_size,
   input logic [DW-1:0] m_wdata,
   input logic [DW-1:0] m_rdata,
   input logic          m_ack
);

   // R4: accesses only happen while the bus is owned
   a_r4_access_owned: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (bus_req && bus_gnt));

   // R4: an acknowledged read is followed by the write
   a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_we && m_ack) |=> (m_valid && m_we));

   // R4: the write carries the data the read returned
   a_r4_data_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_we && m_ack) |=> (m_wdata == $past(m_rdata)));

   // R4: a stalled access keeps its address and direction
   a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ack) |=> (m_valid && $stable(m_addr) && $stable(m_we)));

   // R11: no access is issued with a reserved size or a misaligned address
   a_r11_aligned_access: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (m_size != 2'd3 && !(m_size == 2'd1 && m_addr[0])
                   && !(m_size == 2'd2 && m_addr[1:0] != 2'b00)));

   // R7: ownership ends only right after an acknowledged write
   a_r7_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req) |-> $past(m_valid && m_we && m_ack));

endmodule

bind dma2_ctrl dma2_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/dma2_ctrl_tb.sv
module dma2_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  ext_req = 2'b00;
   logic [1:0]  irq;
   logic        bus_req, bus_gnt, m_valid, m_we, m_ack;
   logic [31:0] m_addr, m_wdata, m_rdata;
   logic [1:0]  m_size;

   int n_run = 0;
   int n_fail = 0;
   int nw = 0;
   int rises = 0;
   logic [31:0] wa [0:511];
   logic [31:0] wd [0:511];
   logic req_d = 1'b0;
   logic tick = 1'b0;
   logic slow = 1'b0;

   always #2 clk = ~clk;

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[15:0] ^ 16'hA5C3, a[15:0]};
   endfunction

   assign bus_gnt = bus_req;
   assign m_ack   = m_valid & (~slow | tick);
   assign m_rdata = pat(m_addr);

   dma2_ctrl #(.CNT_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req(ext_req), .irq(irq),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .m_valid(m_valid), .m_we(m_we),
      .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata),
      .m_ack(m_ack)
   );

   always @(posedge clk) begin
      tick  <= ~tick;
      req_d <= bus_req;
      if (rst_n && bus_req && !req_d) rises <= rises + 1;
      if (rst_n && m_valid && m_ack && m_we) begin
         if (nw < 512) begin
            wa[nw] <= m_addr;
            wd[nw] <= m_wdata;
         end
         nw <= nw + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_sts(input int ch, output logic [31:0] s);
      for (int i = 0; i < 3000; i++) begin
         rd(4'(ch * 8 + 4), s);
         if (s != 0) break;
      end
   endtask

   function automatic logic [31:0] ctl(input int en, input int sz, input int bst,
                                       input int ext, input int ien);
      return 32'(en | (sz << 1) | (bst << 3) | (ext << 4) | (ien << 5));
   endfunction

   task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                        input int n, input logic [31:0] c);
      wr(4'(ch * 8 + 0), s);
      wr(4'(ch * 8 + 1), d);
      wr(4'(ch * 8 + 2), 32'(n));
      wr(4'(ch * 8 + 3), c);
   endtask

   task automatic check_copy(input string req, input int base, input int n,
                             input logic [31:0] s0, input logic [31:0] d0, input int sz);
      for (int i = 0; i < n; i++) begin
         chk(req, wa[base + i], d0 + 32'(i * sz));
         chk(req, wd[base + i], pat(s0 + 32'(i * sz)));
      end
   endtask

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] s, s1;
      int b, r;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk("R1 bus_req", 32'(bus_req), 0);
      chk("R1 irq", 32'(irq), 0);
      rd(4, s);  chk("R1 status ch0", s, 0);
      rd(12, s); chk("R1 status ch1", s, 0);
      rd(13, s); chk("R1 swreq ch1", s, 0);

      // R2 R3 R4 R7 R9 R12: word copy, cycle-steal, software start
      b = nw; r = rises;
      setup(0, 32'h100, 32'h200, 3, ctl(1, 2, 0, 0, 1));
      wr(5, 1);
      wait_sts(0, s);
      chk("R9 done after sw start", s, 1);
      chk("R2 count 3", 32'(nw - b), 3);
      check_copy("R3 R4 word copy", b, 3, 32'h100, 32'h200, 4);
      chk("R7 one request per transfer", 32'(rises - r), 3);
      rd(5, s); chk("R9 sw bit cleared", s, 0);
      chk("R12 irq enabled", 32'(irq[0]), 1);
      wr(4, 3);
      chk("R12 irq cleared by w1c", 32'(irq[0]), 0);

      // R8 R12: half-word burst, interrupt masked
      b = nw; r = rises;
      setup(1, 32'h302, 32'h402, 4, ctl(1, 1, 1, 0, 0));
      wr(13, 1);
      wait_sts(1, s);
      chk("R8 burst done", s, 1);
      check_copy("R3 half copy", b, 4, 32'h302, 32'h402, 2);
      chk("R8 one request per block", 32'(rises - r), 1);
      chk("R12 masked irq", 32'(irq[1]), 0);
      wr(12, 3);

      // R3: byte copy
      b = nw;
      setup(0, 32'h11, 32'h31, 5, ctl(1, 0, 0, 0, 0));
      wr(5, 1);
      wait_sts(0, s);
      chk("R3 byte count", 32'(nw - b), 5);
      check_copy("R3 byte copy", b, 5, 32'h11, 32'h31, 1);
      wr(4, 3);

      // R2: count zero means 256 with CNT_W = 8
      b = nw;
      setup(1, 32'h40, 32'h800, 0, ctl(1, 0, 1, 0, 0));
      wr(13, 1);
      wait_sts(1, s);
      chk("R2 zero count transfers", 32'(nw - b), 256);
      chk("R2 zero count last addr", wa[b + 255], 32'h8FF);
      rd(10, s); chk("R2 count readback", s, 0);
      wr(12, 3);

      // R11: misaligned word source, then reserved size
      b = nw; r = rises;
      setup(0, 32'h102, 32'h200, 2, ctl(1, 2, 0, 0, 1));
      wr(5, 1);
      wait_sts(0, s);
      chk("R11 misaligned error", s, 2);
      chk("R11 no writes", 32'(nw - b), 0);
      chk("R11 no bus request", 32'(rises - r), 0);
      chk("R12 irq on error", 32'(irq[0]), 1);
      wr(4, 3); wr(3, 0);
      setup(0, 32'h100, 32'h200, 2, ctl(1, 3, 0, 0, 0));
      wr(5, 1);
      wait_sts(0, s);
      chk("R11 reserved size error", s, 2);
      chk("R11 reserved size no writes", 32'(nw - b), 0);
      wr(4, 3); wr(3, 0);

      // R10: external request
      b = nw;
      setup(1, 32'h600, 32'h700, 2, ctl(1, 2, 0, 1, 0));
      repeat (40) @(negedge clk);
      rd(12, s);
      chk("R10 idle while ext low", s, 0);
      chk("R10 no writes while ext low", 32'(nw - b), 0);
      ext_req[1] = 1'b1;
      wait_sts(1, s);
      ext_req = 2'b00;
      chk("R10 done with ext high", s, 1);
      check_copy("R10 ext copy", b, 2, 32'h600, 32'h700, 4);
      wr(12, 3);

      // R5: fixed priority, cycle-steal
      wr(7, 0);
      b = nw;
      setup(0, 32'h100, 32'h1000, 2, ctl(1, 2, 0, 1, 0));
      setup(1, 32'h300, 32'h2000, 2, ctl(1, 2, 0, 1, 0));
      ext_req = 2'b11;
      wait_sts(0, s); wait_sts(1, s1);
      ext_req = 2'b00;
      chk("R5 fixed order", {28'd0, wa[b][13], wa[b+1][13], wa[b+2][13], wa[b+3][13]}, 32'b0011);
      wr(4, 3); wr(12, 3);

      // R6: rotating priority, cycle-steal
      wr(7, 1);
      b = nw;
      setup(0, 32'h100, 32'h1000, 2, ctl(1, 2, 0, 1, 0));
      setup(1, 32'h300, 32'h2000, 2, ctl(1, 2, 0, 1, 0));
      ext_req = 2'b11;
      wait_sts(0, s); wait_sts(1, s1);
      ext_req = 2'b00;
      chk("R6 rotating order", {28'd0, wa[b][13], wa[b+1][13], wa[b+2][13], wa[b+3][13]}, 32'b0101);
      wr(4, 3); wr(12, 3);

      // R13: a burst on channel 1 is not preempted by channel 0 under fixed priority
      wr(7, 0);
      b = nw; r = rises;
      setup(0, 32'h100, 32'h1000, 2, ctl(1, 2, 1, 1, 0));
      setup(1, 32'h300, 32'h2000, 3, ctl(1, 2, 1, 1, 0));
      ext_req[1] = 1'b1;
      repeat (3) @(negedge clk);
      ext_req[0] = 1'b1;
      wait_sts(0, s); wait_sts(1, s1);
      ext_req = 2'b00;
      chk("R13 burst not preempted",
          {27'd0, wa[b][13], wa[b+1][13], wa[b+2][13], wa[b+3][13], wa[b+4][13]}, 32'b11100);
      chk("R13 two bursts two requests", 32'(rises - r), 2);
      wr(4, 3); wr(12, 3);

      // R4: stalling acknowledge
      slow = 1'b1;
      b = nw;
      setup(0, 32'h180, 32'h280, 3, ctl(1, 2, 0, 0, 0));
      wr(5, 1);
      wait_sts(0, s);
      slow = 1'b0;
      chk("R4 slow bus count", 32'(nw - b), 3);
      check_copy("R4 slow bus copy", b, 3, 32'h180, 32'h280, 4);
      wr(4, 3);

      summary();
      $finish;
   end

endmodule